// File: doc/BRIEF.md
# Streaming Multi-Word Program Sequencer

This block runs a burst program command for a one-time-programmable array. Once a setup write arrives, the host streams data words. The first word carries a start address. Each later word carries only a continue marker in its upper address bits, and an internal counter steps the target location. A write whose upper address bits differ from those of the start address closes the program pass. The host then sends the same words a second time. Each resent word is compared against the array contents. A location that does not match is programmed again, up to a set number of attempts.

The array write itself is modelled by a start/done handshake. Comparison uses a read port into the array. The host polls a ready bit and sends the next word only when that bit is low. While the block is busy, a write is dropped and a sticky overrun flag is raised. The sequence has no abort. After a failure, only a clear write returns the block to idle. A status-read strobe flips a toggle bit while a sequence is active.

Top module: `burst_prog_seq`

## Requirements
- R1: After reset the block is idle. sts_active, sts_ready, sts_err, sts_vpp_err, sts_ovr, sts_toggle and arr_wr_start are all 0.
- R2: In idle, a write with wr_addr[10:0]=555h and wr_data[7:0]=20h starts a sequence (sts_active=1), but only if vpp_ok=1. Any other write in idle, or this write with vpp_ok=0, leaves the block idle.
- R3: The first write after setup captures the start address and data. It issues exactly one array write of that data at that address.
- R4: A later write whose wr_addr[19:17] equals the start address's bits 19:17 is a continue write. Its data is programmed at the previous location plus one, and wr_addr[16:0] is ignored.
- R5: A write whose wr_addr[19:17] differs from the start address ends the pass. Its data is ignored and no array write is issued.
- R6: The verify pass uses the same start, continue and final pattern. Words that match the array cause no array write. The final write of this pass returns the block to idle with sts_err=0.
- R7: A mismatching word is reprogrammed (the array ANDs the new data into the location) up to RETRY times (default 1). If the location then matches, the sequence continues without error.
- R8: A mismatch that remains after all retries, such as a bit that would need to go from 0 to 1, sets sts_err=1. The block stays active, and every later write except the clear code is ignored.
- R9: If vpp_ok falls while an array write is pending, the sequence stops and both sts_err and sts_vpp_err are set.
- R10: sts_ready is 1 from the edge that accepts a word until the array reports done and the compare has finished. In every other cycle it is 0.
- R11: While a sequence runs, writes of F0h or of the setup code are treated as data. Only in the failure state does a write with wr_data[7:0]=F0h return the block to idle and clear both error flags.
- R12: A write made while sts_ready=1 is dropped and sets sts_ovr, which holds until reset.
- R13: Each rd_stb while sts_active=1 inverts sts_toggle. In idle, rd_stb has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host bus write strobe |
| wr_addr | input | 20 | Host write address |
| wr_data | input | 16 | Host write data |
| rd_stb | input | 1 | Status read strobe |
| vpp_ok | input | 1 | Program voltage present |
| arr_wr_start | output | 1 | One-cycle array write request |
| arr_wr_addr | output | 20 | Array write address |
| arr_wr_data | output | 16 | Array write data |
| arr_wr_done | input | 1 | Array write complete |
| arr_rd_addr | output | 20 | Array read address for verify |
| arr_rd_data | input | 16 | Array read data |
| sts_active | output | 1 | Sequence in progress or failed |
| sts_ready | output | 1 | 1 = busy, 0 = next word accepted |
| sts_err | output | 1 | Verify or voltage failure |
| sts_vpp_err | output | 1 | Failure caused by voltage loss |
| sts_toggle | output | 1 | Flips on each status read while active |
| sts_ovr | output | 1 | Sticky dropped-write flag |

## Verification
A table of single-word bursts covers four verify outcomes: an exact match, a match after a cleared bit is reprogrammed, an unresolvable 0-to-1 request, and a start address with a nonzero upper tag. Together they separate a plain pass, a successful retry, and a hard failure with a correct clear. A multi-word burst uses continue addresses with arbitrary low bits and embeds the clear code as data. This shows that the internal counter, not the bus address, picks each location, and that the final write programs nothing. Further directed cases cover a write during busy, voltage loss mid-write, setup with a wrong code, a wrong address or no voltage, and status reads in idle versus active.

// File: rtl/burst_prog_seq.sv
module burst_prog_seq #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int HI_LSB     = 17,
  parameter int CMD_AW     = 11,
  parameter int RETRY      = 1,
  parameter logic [CMD_AW-1:0] CMD_ADDR = 11'h555,
  parameter logic [7:0] SETUP_CODE = 8'h20,
  parameter logic [7:0] CLEAR_CODE = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stb,
  input  logic          vpp_ok,
  output logic          arr_wr_start,
  output logic [AW-1:0] arr_wr_addr,
  output logic [DW-1:0] arr_wr_data,
  input  logic          arr_wr_done,
  output logic [AW-1:0] arr_rd_addr,
  input  logic [DW-1:0] arr_rd_data,
  output logic          sts_active,
  output logic          sts_ready,
  output logic          sts_err,
  output logic          sts_vpp_err,
  output logic          sts_toggle,
  output logic          sts_ovr
);
  localparam int RW = (RETRY < 1) ? 1 : $clog2(RETRY + 1);
  localparam logic [AW-1:0] ONE = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_P_START, S_P_NEXT, S_P_BUSY,
    S_V_START, S_V_NEXT, S_V_CMP, S_V_BUSY, S_FAIL
  } state_t;

  state_t               state;
  logic [AW-1:0]        waddr;
  logic [DW-1:0]        wdata;
  logic [AW-1:HI_LSB]   hi_tag;
  logic [RW-1:0]        tries;
  logic                 start;

  assign sts_ready   = (state == S_P_BUSY) || (state == S_V_CMP) || (state == S_V_BUSY);
  assign sts_active  = (state != S_IDLE);
  assign arr_wr_start = start;
  assign arr_wr_addr = waddr;
  assign arr_wr_data = wdata;
  assign arr_rd_addr = waddr;

  wire accept  = wr_en && !sts_ready;
  wire same_hi = (wr_addr[AW-1:HI_LSB] == hi_tag);
  wire is_setup = (wr_addr[CMD_AW-1:0] == CMD_ADDR) && (wr_data[7:0] == SETUP_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      waddr       <= '0;
      wdata       <= '0;
      hi_tag      <= '0;
      tries       <= '0;
      start       <= 1'b0;
      sts_err     <= 1'b0;
      sts_vpp_err <= 1'b0;
      sts_toggle  <= 1'b0;
      sts_ovr     <= 1'b0;
    end else begin
      start <= 1'b0;
      if (rd_stb && state != S_IDLE) sts_toggle <= ~sts_toggle;
      if (wr_en && sts_ready) sts_ovr <= 1'b1;
      case (state)
        S_IDLE:
          if (accept && is_setup && vpp_ok) state <= S_P_START;
        S_P_START:
          if (accept) begin
            hi_tag <= wr_addr[AW-1:HI_LSB];
            waddr  <= wr_addr;
            wdata  <= wr_data;
            start  <= 1'b1;
            state  <= S_P_BUSY;
          end
        S_P_NEXT:
          if (accept) begin
            if (same_hi) begin
              waddr <= waddr + ONE;
              wdata <= wr_data;
              start <= 1'b1;
              state <= S_P_BUSY;
            end else begin
              state <= S_V_START;
            end
          end
        S_V_START:
          if (accept) begin
            hi_tag <= wr_addr[AW-1:HI_LSB];
            waddr  <= wr_addr;
            wdata  <= wr_data;
            tries  <= '0;
            state  <= S_V_CMP;
          end
        S_V_NEXT:
          if (accept) begin
            if (same_hi) begin
              waddr <= waddr + ONE;
              wdata <= wr_data;
              tries <= '0;
              state <= S_V_CMP;
            end else begin
              state <= S_IDLE;
            end
          end
        S_V_CMP:
          if (arr_rd_data == wdata) begin
            state <= S_V_NEXT;
          end else if (tries < RW'(RETRY)) begin
            tries <= tries + RW'(1);
            start <= 1'b1;
            state <= S_V_BUSY;
          end else begin
            sts_err <= 1'b1;
            state   <= S_FAIL;
          end
        S_P_BUSY, S_V_BUSY:
          if (!vpp_ok) begin
            sts_err     <= 1'b1;
            sts_vpp_err <= 1'b1;
            state       <= S_FAIL;
          end else if (arr_wr_done) begin
            state <= (state == S_P_BUSY) ? S_P_NEXT : S_V_CMP;
          end
        S_FAIL:
          if (accept && wr_data[7:0] == CLEAR_CODE) begin
            sts_err     <= 1'b0;
            sts_vpp_err <= 1'b0;
            state       <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_prog_seq_chk.sv
module burst_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_lo,
  input logic       rd_stb,
  input logic       arr_wr_start,
  input logic       sts_active,
  input logic       sts_ready,
  input logic       sts_err,
  input logic       sts_vpp_err,
  input logic       sts_toggle,
  input logic       sts_ovr
);
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_start |-> sts_ready); // R10
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_start |=> !arr_wr_start); // R3
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_active |-> !arr_wr_start && !sts_ready && !sts_err); // R2
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_err && !(wr_en && wr_lo == 8'hF0) |=> sts_err); // R8
  AST_VPP_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_vpp_err |-> sts_err); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ovr |=> sts_ovr); // R12
  AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_active |=> $stable(sts_toggle)); // R13
endmodule

bind burst_prog_seq burst_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo(wr_data[7:0]), .rd_stb(rd_stb),
  .arr_wr_start(arr_wr_start), .sts_active(sts_active), .sts_ready(sts_ready),
  .sts_err(sts_err), .sts_vpp_err(sts_vpp_err), .sts_toggle(sts_toggle), .sts_ovr(sts_ovr)
);

// File: tb/burst_prog_seq_tb.sv
module burst_prog_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [19:0] wr_addr;
  logic [15:0] wr_data;
  logic        rd_stb;
  logic        vpp_ok;
  logic        arr_wr_start;
  logic [19:0] arr_wr_addr;
  logic [15:0] arr_wr_data;
  logic        arr_wr_done;
  logic [19:0] arr_rd_addr;
  logic [15:0] arr_rd_data;
  logic        sts_active, sts_ready, sts_err, sts_vpp_err, sts_toggle, sts_ovr;

  always #4 clk = ~clk;

  burst_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .vpp_ok(vpp_ok), .arr_wr_start(arr_wr_start),
    .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data), .arr_wr_done(arr_wr_done),
    .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data), .sts_active(sts_active),
    .sts_ready(sts_ready), .sts_err(sts_err), .sts_vpp_err(sts_vpp_err),
    .sts_toggle(sts_toggle), .sts_ovr(sts_ovr)
  );

  // array model: 64 words, writes AND in after a short latency
  logic [15:0] mem [0:63];
  logic [1:0]  lat;
  logic [19:0] la;
  logic [15:0] ld;
  int          nwr;
  assign arr_rd_data = mem[arr_rd_addr[5:0]];

  always @(posedge clk) begin
    arr_wr_done <= 1'b0;
    if (!rst_n) begin
      lat <= 0;
      nwr <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= 16'hFFFF;
    end else if (arr_wr_start) begin
      lat <= 3; la <= arr_wr_addr; ld <= arr_wr_data;
    end else if (lat == 1) begin
      lat <= 0;
      arr_wr_done <= 1'b1;
      mem[la[5:0]] <= mem[la[5:0]] & ld;
      nwr <= nwr + 1;
    end else if (lat > 1) begin
      lat <= lat - 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle_ready();
    for (int n = 0; n < 1000 && sts_ready; n++) @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle_ready();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  // {start addr, program data, verify data, expected error}
  localparam logic [52:0] VEC [0:5] = '{
    {20'h00003, 16'hA5A5, 16'hA5A5, 1'b0},
    {20'h00004, 16'h0000, 16'h0000, 1'b0},
    {20'h00005, 16'h00FF, 16'h01FF, 1'b1},
    {20'h20006, 16'h1234, 16'h1234, 1'b0},
    {20'h00007, 16'hFFFF, 16'hFFFE, 1'b0},
    {20'h00008, 16'hF0F0, 16'hF0F0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] a, fa;
    logic [15:0] p, v;
    logic        e;
    int          n0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_stb = 0; vpp_ok = 1;
    do_reset();

    // R1 reset state
    chk("R1 active", sts_active, 0);
    chk("R1 ready", sts_ready, 0);
    chk("R1 err", {sts_err, sts_vpp_err}, 0);
    chk("R1 ovr/toggle", {sts_ovr, sts_toggle}, 0);
    chk("R1 start", arr_wr_start, 0);

    // table of single-word bursts: R6 R7 R8
    for (int i = 0; i < 6; i++) begin
      a = VEC[i][52:33]; p = VEC[i][32:17]; v = VEC[i][16:1]; e = VEC[i][0];
      fa = a ^ 20'h20000;
      wr(20'h00555, 16'h0020);
      wr(a, p);
      wr(fa, 16'h0000);
      wr(a, v);
      wr(fa, 16'h0000);
      chk("R8 vector err", sts_err, e);
      chk("R6 vector active", sts_active, e);
      chk("R7 vector mem", mem[a[5:0]], p & v);
      if (e) begin
        wr(20'h00000, 16'h00F0);
        chk("R11 clear after fail", {sts_active, sts_err}, 0);
      end
    end

    // R2 setup rejection
    vpp_ok = 0;
    wr(20'h00555, 16'h0020);
    chk("R2 no vpp", sts_active, 0);
    vpp_ok = 1;
    wr(20'h00555, 16'h0021);
    chk("R2 wrong code", sts_active, 0);
    wr(20'h00554, 16'h0020);
    chk("R2 wrong addr", sts_active, 0);
    wr(20'h00000, 16'h00F0);
    chk("R11 clear in idle", sts_active, 0);

    // multi-word burst: R3 R4 R5 R11, verify R6
    n0 = nwr;
    wr(20'h00555, 16'h0020);
    wr(20'h40010, 16'h1111);
    chk("R3 first word", mem[16], 16'h1111);
    wr(20'h4FFFF, 16'h2222);
    wr(20'h40000, 16'h00F0);
    wr(20'h60000, 16'h9999);
    chk("R4 second word", mem[17], 16'h2222);
    chk("R11 code as data", mem[18], 16'h00F0);
    chk("R5 final ignored", mem[19], 16'hFFFF);
    chk("R5 write count", nwr - n0, 3);
    chk("R5 still active", sts_active, 1);
    wr(20'h40010, 16'h1111);
    wr(20'h40000, 16'h2222);
    wr(20'h5ABCD, 16'h00F0);
    wr(20'h60000, 16'h0000);
    chk("R6 no rewrites", nwr - n0, 3);
    chk("R6 done", {sts_active, sts_err}, 0);

    // R10 ready timing, R12 overrun
    n0 = nwr;
    wr(20'h00555, 16'h0020);
    @(negedge clk);
    wr_en = 1; wr_addr = 20'h00020; wr_data = 16'h1357;
    @(negedge clk);
    wr_en = 0;
    chk("R10 ready after accept", sts_ready, 1);
    chk("R3 start pulse", arr_wr_start, 1);
    wr_en = 1; wr_addr = 20'h00020; wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 0;
    chk("R12 ovr set", sts_ovr, 1);
    wait_idle_ready();
    chk("R10 ready low", sts_ready, 0);
    chk("R12 dropped word", mem[33], 16'hFFFF);
    chk("R12 one write", nwr - n0, 1);
    wr(20'h20000, 16'h0000);
    wr(20'h00020, 16'h1357);
    wr(20'h20000, 16'h0000);
    chk("R12 ovr sticky", {sts_ovr, sts_active, sts_err}, 3'b100);

    // R9 voltage loss
    do_reset();
    chk("R12 ovr reset", sts_ovr, 0);
    wr(20'h00555, 16'h0020);
    @(negedge clk);
    wr_en = 1; wr_addr = 20'h00030; wr_data = 16'h0F0F;
    @(negedge clk);
    wr_en = 0; vpp_ok = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 flags", {sts_err, sts_vpp_err}, 2'b11);
    chk("R9 active", sts_active, 1);
    wr(20'h00555, 16'h0020);
    chk("R8 ignored in fail", {sts_active, sts_err}, 2'b11);
    wr(20'h00000, 16'h00F0);
    chk("R11 clear", {sts_active, sts_err, sts_vpp_err}, 0);
    vpp_ok = 1;

    // R13 toggle
    do_reset();
    strobe();
    chk("R13 idle toggle", sts_toggle, 0);
    wr(20'h00555, 16'h0020);
    strobe();
    chk("R13 toggle 1", sts_toggle, 1);
    strobe();
    chk("R13 toggle 0", sts_toggle, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule